// File: doc/BRIEF.md
# Half-Duplex Serial Transmitter with Driver Hand-Over Control

This block serialises bytes onto a two-wire half-duplex differential bus and drives the line transceiver's driver-enable pin itself. Software never has to time the enable. Bytes arrive on a valid/ready stream, and the last byte of a frame is marked. Each byte leaves as one character: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts `CLK_DIV` clock cycles. The bytes of one frame follow each other with no idle time between them.

The driver enable stays high until the stop bit of the final byte has spent its whole bit time on the line. If the driver were released earlier, the bus bias would pull the undriven upper data bits to one and corrupt them. A one-cycle done pulse marks the moment the driver is released.

Before each frame, a configurable hand-over scheme gives the previous talker time to release the bus. There are four schemes:
- start at once;
- wait a guard interval, counted in half-character steps;
- clock a number of all-ones characters through the shifter with the driver still off;
- turn the driver on at once and send a number of all-ones lead-in characters ahead of the payload.

Top module: `hdx_line_tx`

## Requirements
- R1: After reset `txd` is 1, `drv_en` is 0, `tx_done` is 0 and `s_ready` is 0.
- R2: Each byte leaves as 10 bits of `CLK_DIV` cycles each: a 0 start bit, data bits 0 to 7 in that order, then a 1 stop bit. `txd` is 1 whenever no character is being shifted.
- R3: While `s_valid` stays high, successive bytes of one frame leave back to back. With P payload bytes, `drv_en` is high for exactly 10·P·`CLK_DIV`+1 cycles in direct, guard and dummy modes.
- R4: `drv_en` falls at the clock edge that ends the last stop bit of the frame, and never before it.
- R5: `tx_done` is high for exactly one cycle per frame, and that cycle is the first cycle in which `drv_en` is low again.
- R6: Mode `cfg_mode`=0 (direct): `drv_en` rises on the edge at which the idle block first sees `s_valid`.
- R7: Mode 1 (guard): for H = `cfg_guard_half`, `drv_en` stays low and `txd` stays 1 for 5·H bit times after the frame request. `drv_en` then rises on the following edge.
- R8: In guard mode, H = 0 selects the preset `GUARD_PRESET_HALF` (default 7, which is 3.5 character times).
- R9: Mode 2 (dummy): N = `cfg_count` characters of value 0xFF are shifted out on `txd` with `drv_en` low. `drv_en` rises on the edge that ends the last dummy stop bit. These characters are never sent with the driver on.
- R10: Mode 3 (lead-in): `drv_en` rises at once, and max(N, `PREAMBLE_MIN`) characters of 0xFF are sent with the driver on, directly ahead of the payload (default minimum 2).
- R11: `s_ready` is high only when the driver is on and the shifter can take a byte in that cycle, so no payload byte is taken before the hand-over phase ends.
- R12: The mode and counts are taken when a frame starts, at the edge where the idle block sees `s_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Hand-over scheme: 0 direct, 1 guard, 2 dummy, 3 lead-in |
| cfg_guard_half | input | GUARD_W | Guard length in half characters; 0 selects the preset |
| cfg_count | input | CFG_CNT_W | Number of dummy characters or lead-in characters |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| s_ready | output | 1 | Byte accepted on this cycle's edge when `s_valid` is high |
| txd | output | 1 | Serial line to the transceiver |
| drv_en | output | 1 | Transceiver driver enable |
| tx_done | output | 1 | One-cycle pulse when the frame has fully left |

## Verification
The bench measures the exact width of the driver-enable window. A design that releases the driver when the last byte is loaded would show a window one character short, and its decoded stop bit would fail. A design that leaves gaps between bytes would show a window that is too long.

Each hand-over mode is checked by the cycle at which the driver rises. In dummy mode the bench also counts start edges on the line while the driver is off, and it confirms that the lead-in count is clamped to 2 when a count of 1 is requested. A guard counter off by one tick, or a zero setting that skipped the preset, would move the rise cycle by whole bit times. A lead-in phase that accepted payload early would show up in the recorded handshake cycle.

// File: rtl/hdx_line_pkg.sv
package hdx_line_pkg;
  localparam int unsigned BITS_PER_CHAR  = 10;
  localparam int unsigned HALF_CHAR_BITS = 5;
  localparam int unsigned CNT_W          = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GUARD, ST_DUMMY, ST_PREAMBLE, ST_DATA, ST_DRAIN
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_GUARD    = 2'd1,
    MODE_DUMMY    = 2'd2,
    MODE_PREAMBLE = 2'd3
  } handover_mode_t;

  // bit ticks spent in guard; zero request falls back to the preset
  function automatic logic [CNT_W-1:0] guard_ticks(input logic [CNT_W-1:0] half_req,
                                                   input logic [CNT_W-1:0] half_preset);
    logic [CNT_W-1:0] h;
    h = (half_req == '0) ? half_preset : half_req;
    return h * CNT_W'(HALF_CHAR_BITS);
  endfunction

  // lead-in character count, never below the minimum
  function automatic logic [CNT_W-1:0] preamble_chars(input logic [CNT_W-1:0] req,
                                                      input logic [CNT_W-1:0] min_chars);
    return (req < min_chars) ? min_chars : req;
  endfunction
endpackage

// File: rtl/hdx_bit_tick.sv
module hdx_bit_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || cnt == LAST) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/hdx_char_shifter.sv
module hdx_char_shifter
  import hdx_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  output logic       line,
  output logic       busy,
  output logic       char_end
);
  localparam int unsigned BW = $clog2(BITS_PER_CHAR);
  localparam logic [BW-1:0] LAST_BIT = BW'(BITS_PER_CHAR - 1);

  logic [BITS_PER_CHAR-1:0] sh;
  logic [BW-1:0]            bitc;

  // stop bit is over only when its own last tick arrives
  assign char_end = busy && tick && (bitc == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      bitc <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh   <= {1'b1, din, 1'b0};
      bitc <= '0;
      busy <= 1'b1;
    end else if (char_end) begin
      sh   <= '1;
      busy <= 1'b0;
    end else if (busy && tick) begin
      sh   <= {1'b1, sh[BITS_PER_CHAR-1:1]};
      bitc <= bitc + 1'b1;
    end
  end

  assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/hdx_handover_seq.sv
module hdx_handover_seq
  import hdx_line_pkg::*;
#(
  parameter int unsigned GUARD_W           = 8,
  parameter int unsigned CFG_CNT_W         = 4,
  parameter int unsigned GUARD_PRESET_HALF = 7,
  parameter int unsigned PREAMBLE_MIN      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic [GUARD_W-1:0]   cfg_guard_half,
  input  logic [CFG_CNT_W-1:0] cfg_count,
  input  logic                 s_valid,
  input  logic                 s_last,
  input  logic                 tick,
  input  logic                 busy,
  input  logic                 char_end,
  output logic                 load,
  output logic                 fill,
  output logic                 s_ready,
  output logic                 drv_en,
  output logic                 tx_done,
  output logic                 guard_run
);
  localparam logic [CNT_W-1:0] PRESET = CNT_W'(GUARD_PRESET_HALF);
  localparam logic [CNT_W-1:0] PMIN   = CNT_W'(PREAMBLE_MIN);

  seq_state_t       st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             slot;

  assign slot      = !busy || char_end;
  assign guard_run = (st == ST_GUARD);
  assign drv_en    = (st == ST_PREAMBLE) || (st == ST_DATA) || (st == ST_DRAIN);

  always_comb begin
    st_nx   = st;
    cnt_nx  = cnt;
    load    = 1'b0;
    fill    = 1'b0;
    s_ready = 1'b0;
    unique case (st)
      ST_IDLE: if (s_valid) begin
        unique case (handover_mode_t'(cfg_mode))
          MODE_DIRECT: st_nx = ST_DATA;
          MODE_GUARD: begin
            st_nx  = ST_GUARD;
            cnt_nx = guard_ticks(CNT_W'(cfg_guard_half), PRESET);
          end
          MODE_DUMMY: begin
            st_nx  = (cfg_count == '0) ? ST_DATA : ST_DUMMY;
            cnt_nx = CNT_W'(cfg_count);
          end
          MODE_PREAMBLE: begin
            st_nx  = ST_PREAMBLE;
            cnt_nx = preamble_chars(CNT_W'(cfg_count), PMIN);
          end
          default: st_nx = ST_DATA;
        endcase
      end
      ST_GUARD: if (tick) begin
        cnt_nx = cnt - 1'b1;
        if (cnt == CNT_W'(1)) st_nx = ST_DATA;
      end
      ST_DUMMY: begin
        if (slot && cnt != '0) begin
          load   = 1'b1;
          fill   = 1'b1;
          cnt_nx = cnt - 1'b1;
        end else if (char_end) begin
          st_nx = ST_DATA;
        end
      end
      ST_PREAMBLE: begin
        if (slot && cnt != '0) begin
          load   = 1'b1;
          fill   = 1'b1;
          cnt_nx = cnt - 1'b1;
        end else if (char_end) begin
          s_ready = 1'b1;
          load    = s_valid;
          st_nx   = (s_valid && s_last) ? ST_DRAIN : ST_DATA;
        end
      end
      ST_DATA: begin
        s_ready = slot;
        load    = slot && s_valid;
        if (slot && s_valid && s_last) st_nx = ST_DRAIN;
      end
      ST_DRAIN: if (char_end) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      tx_done <= 1'b0;
    end else begin
      st      <= st_nx;
      cnt     <= cnt_nx;
      tx_done <= (st == ST_DRAIN) && char_end;
    end
  end
endmodule

// File: rtl/hdx_line_tx.sv
module hdx_line_tx #(
  parameter int unsigned CLK_DIV           = 8,
  parameter int unsigned GUARD_W           = 8,
  parameter int unsigned CFG_CNT_W         = 4,
  parameter int unsigned GUARD_PRESET_HALF = 7,
  parameter int unsigned PREAMBLE_MIN      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic [GUARD_W-1:0]   cfg_guard_half,
  input  logic [CFG_CNT_W-1:0] cfg_count,
  input  logic                 s_valid,
  input  logic [7:0]           s_data,
  input  logic                 s_last,
  output logic                 s_ready,
  output logic                 txd,
  output logic                 drv_en,
  output logic                 tx_done
);
  logic tick, sh_busy, char_end, load, fill, guard_run;
  logic [7:0] din;

  assign din = fill ? 8'hFF : s_data;

  hdx_bit_tick #(.DIV(CLK_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .run(sh_busy || guard_run), .tick(tick)
  );

  hdx_char_shifter i_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .din(din),
    .line(txd), .busy(sh_busy), .char_end(char_end)
  );

  hdx_handover_seq #(
    .GUARD_W(GUARD_W), .CFG_CNT_W(CFG_CNT_W),
    .GUARD_PRESET_HALF(GUARD_PRESET_HALF), .PREAMBLE_MIN(PREAMBLE_MIN)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_guard_half(cfg_guard_half),
    .cfg_count(cfg_count), .s_valid(s_valid), .s_last(s_last), .tick(tick),
    .busy(sh_busy), .char_end(char_end), .load(load), .fill(fill),
    .s_ready(s_ready), .drv_en(drv_en), .tx_done(tx_done), .guard_run(guard_run)
  );
endmodule

// File: rtl/hdx_line_tx_chk.sv
module hdx_line_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic drv_en,
  input logic tx_done,
  input logic s_ready,
  input logic busy,
  input logic char_end,
  input logic in_guard
);
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!drv_en && $past(drv_en)));                       // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);                                         // R5
  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en) |-> $past(char_end));                            // R4
  AST_READY_NEEDS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> drv_en);                                           // R11
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);                                                // R2
  AST_GUARD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_guard |-> (txd && !drv_en));                                // R7
endmodule

bind hdx_line_tx hdx_line_tx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .drv_en(drv_en), .tx_done(tx_done),
  .s_ready(s_ready), .busy(sh_busy), .char_end(char_end), .in_guard(guard_run)
);

// File: tb/test_hdx_line_tx.sv
`timescale 1ns/1ps
module test_hdx_line_tx;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [7:0] cfg_guard_half = 8'd0;
  logic [3:0] cfg_count = 4'd0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = 8'd0;
  logic s_last = 1'b0;
  logic s_ready, txd, drv_en, tx_done;

  always #2.5 clk = ~clk;

  hdx_line_tx #(.CLK_DIV(DIV)) i_hdx_line_tx (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_guard_half(cfg_guard_half),
    .cfg_count(cfg_count), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_ready(s_ready), .txd(txd), .drv_en(drv_en), .tx_done(tx_done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // line monitor
  int rise_cyc, fall_cyc, done_cyc, done_cnt, off_falls, off_low, stop_err, rx_n;
  logic [7:0] rx_q [0:15];
  logic de_prev = 1'b0, txd_prev = 1'b1;
  bit dec_on = 0;
  int ph = 0;
  logic [7:0] dec_byte;

  always @(negedge clk) begin
    if (rst_n) begin
      if (drv_en && !de_prev) rise_cyc = cyc;
      if (!drv_en && de_prev) fall_cyc = cyc;
      if (tx_done) begin done_cyc = cyc; done_cnt++; end
      if (!drv_en && txd_prev && !txd) off_falls++;
      if (!drv_en && !txd) off_low++;
      if (!dec_on) begin
        if (drv_en && !txd) begin dec_on = 1; ph = 0; end
      end else begin
        ph++;
        if (ph == DIV/2 && txd) stop_err++;
        if (ph > DIV && ((ph - DIV/2) % DIV) == 0) begin
          int idx;
          idx = (ph - DIV/2) / DIV;
          if (idx <= 8) dec_byte[idx-1] = txd;
          else begin
            if (!txd) stop_err++;
            if (rx_n < 16) rx_q[rx_n] = dec_byte;
            rx_n++;
            dec_on = 0;
          end
        end
      end
    end
    de_prev = drv_en;
    txd_prev = txd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [7:0] pl [0:7];
  int start_c, hs_c;

  task automatic send_frame(input logic [1:0] mode, input logic [7:0] gh,
                            input logic [3:0] cnt, input int n);
    @(negedge clk);
    rise_cyc = -1; fall_cyc = -1; done_cyc = -2; done_cnt = 0;
    off_falls = 0; off_low = 0; stop_err = 0; rx_n = 0; hs_c = -1;
    cfg_mode = mode; cfg_guard_half = gh; cfg_count = cnt;
    start_c = cyc;
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = pl[i]; s_last = (i == n-1);
      while (!s_ready) @(negedge clk);
      if (i == 0) hs_c = cyc;
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
    // R12: config changes after the frame started must not matter
    cfg_mode = 2'd1; cfg_guard_half = 8'd9; cfg_count = 4'd9;
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_payload(input int offset, input int n, input string req);
    for (int i = 0; i < n; i++)
      chk(rx_q[offset+i] == pl[i], req, rx_q[offset+i], pl[i]);
  endtask

  task automatic chk_end(input int n);
    chk(done_cyc == fall_cyc, "R5 done with release", done_cyc, fall_cyc);
    chk(done_cnt == 1, "R5 one pulse", done_cnt, 1);
    chk(stop_err == 0, "R2 framing", stop_err, 0);
    chk(fall_cyc - rise_cyc == 10*n*DIV + 1, "R3 R4 driver window",
        fall_cyc - rise_cyc, 10*n*DIV + 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(drv_en == 1'b0, "R1 drv_en", drv_en, 0);
    chk(tx_done == 1'b0, "R1 tx_done", tx_done, 0);
    chk(s_ready == 1'b0, "R1 s_ready", s_ready, 0);
  endtask

  task automatic t_direct;
    pl[0] = 8'hA5; pl[1] = 8'h01; pl[2] = 8'h80;
    send_frame(2'd0, 8'd0, 4'd0, 3);
    chk(rise_cyc - start_c == 1, "R6 direct rise", rise_cyc - start_c, 1);
    chk(hs_c - start_c == 1, "R11 direct accept", hs_c - start_c, 1);
    chk(rx_n == 3, "R2 byte count", rx_n, 3);
    chk_payload(0, 3, "R2 data");
    chk_end(3);
    chk(off_low == 0, "R9 no line activity with driver off", off_low, 0);
  endtask

  task automatic t_single_msb;
    pl[0] = 8'hFE;
    send_frame(2'd0, 8'd0, 4'd0, 1);
    chk(rx_n == 1 && rx_q[0] == 8'hFE, "R4 last byte intact", rx_q[0], 8'hFE);
    chk_end(1);
  endtask

  task automatic t_guard;
    pl[0] = 8'h3C; pl[1] = 8'hC3;
    send_frame(2'd1, 8'd2, 4'd0, 2);
    chk(rise_cyc - start_c == 10*DIV + 1, "R7 guard rise", rise_cyc - start_c, 10*DIV + 1);
    chk(off_low == 0, "R7 guard quiet", off_low, 0);
    chk_payload(0, 2, "R7 data");
    chk_end(2);
  endtask

  task automatic t_guard_preset;
    pl[0] = 8'h5A;
    send_frame(2'd1, 8'd0, 4'd0, 1);
    chk(rise_cyc - start_c == 35*DIV + 1, "R8 preset guard", rise_cyc - start_c, 35*DIV + 1);
    chk_end(1);
  endtask

  task automatic t_dummy;
    pl[0] = 8'h12; pl[1] = 8'h34;
    send_frame(2'd2, 8'd0, 4'd3, 2);
    chk(rise_cyc - start_c == 30*DIV + 2, "R9 dummy rise", rise_cyc - start_c, 30*DIV + 2);
    chk(off_falls == 3, "R9 dummy chars", off_falls, 3);
    chk(rx_n == 2, "R9 dummies not driven", rx_n, 2);
    chk_payload(0, 2, "R9 data");
    chk_end(2);
  endtask

  task automatic t_preamble(input logic [3:0] req, input int exp_pre);
    pl[0] = 8'h68; pl[1] = 8'h00; pl[2] = 8'hF0;
    send_frame(2'd3, 8'd0, req, 3);
    chk(rise_cyc - start_c == 1, "R10 lead-in rise", rise_cyc - start_c, 1);
    chk(hs_c - start_c == 10*exp_pre*DIV + 1, "R11 lead-in accept",
        hs_c - start_c, 10*exp_pre*DIV + 1);
    chk(rx_n == exp_pre + 3, "R10 lead-in count", rx_n, exp_pre + 3);
    for (int i = 0; i < exp_pre; i++)
      chk(rx_q[i] == 8'hFF, "R10 lead-in value", rx_q[i], 8'hFF);
    chk_payload(exp_pre, 3, "R10 R12 payload");
    chk(done_cnt == 1, "R5 one pulse", done_cnt, 1);
    chk(fall_cyc - rise_cyc == 10*(exp_pre+3)*DIV + 1, "R3 R10 window",
        fall_cyc - rise_cyc, 10*(exp_pre+3)*DIV + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_direct;
    t_single_msb;
    t_guard;
    t_guard_preset;
    t_dummy;
    t_preamble(4'd1, 2);
    t_preamble(4'd4, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule